// File: doc/BRIEF.md
# Hardware Breakpoint Slot Pool

This block keeps a small, packed table of instruction-address breakpoints and compares the live fetch address against all of them at once. A host-side command port accepts one command per cycle. Insert builds a slot from a plain address. Delete removes the first slot whose stored address equals the given one. Clear empties the table. Each command gets a one-cycle done pulse with an error code.

Every slot holds a 32-bit control word and a 64-bit value word. On insert the control word is formed with fixed enable, privilege and byte-select encodings. The value word is the address sign-extended from bit 52. Active slots always occupy indices 0 to count-1. A delete closes the gap by moving every higher slot down one place in the same clock edge, so the match logic never sees a half-moved table.

A combinational read port returns any slot's two words so the host can inspect the table.

Top module: `bkpt_pool`

## Requirements
- R1: An accepted insert writes control word 32'h0000_01E7 into slot index `activeCount`. In that word bit 0 is the enable, bits [2:1] are 2'b11 (all privilege levels), bits [8:5] are 4'b1111 (all bytes), and every other bit is 0.
- R2: An accepted insert stores the value word as `cmdAddr[52:0]` with bits [63:53] copying bit 52. The count then grows by one.
- R3: An insert when `activeCount` equals NUM_SLOTS changes nothing and responds with error 2'b01 (no space).
- R4: A delete scans the active slots from index 0 upward and takes the first whose value word equals `cmdAddr` (all 64 bits). It removes that slot, moves every higher slot down by one keeping their order, and lowers the count by one.
- R5: A delete that matches no active slot changes nothing and responds with error 2'b10 (not found).
- R6: `pcHit` is high in the same cycle that `pc` equals the value word of any active slot, and low otherwise. Inactive slots never match.
- R7: `debugActive` is high exactly when `activeCount` is non-zero. `full` is high exactly when `activeCount` equals NUM_SLOTS.
- R8: A clear command empties the table (count 0, all slots zero). Synchronous active-low reset does the same, and also leaves `rspDone` low.
- R9: Each cycle with `cmdValid` high produces `rspDone` high in the next cycle, with `rspErr` 2'b00 on success. Op encodings are 2'b00 insert, 2'b01 delete and 2'b10 clear. Op 2'b11 is acknowledged with 2'b00 and changes nothing.
- R10: The read port returns slot `rdIdx` when `rdIdx` is below `activeCount`, and zero for both words otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdOp | input | 2 | 00 insert, 01 delete, 10 clear, 11 no operation |
| cmdAddr | input | 64 | Address for insert or delete |
| pc | input | 64 | Current fetch address |
| rdIdx | input | IDX_W | Slot index for table readback |
| pcHit | output | 1 | Fetch address matches an active slot |
| activeCount | output | CNT_W | Number of active slots |
| full | output | 1 | All slots in use |
| debugActive | output | 1 | At least one breakpoint present |
| rspDone | output | 1 | Response strobe for the previous command |
| rspErr | output | 2 | 00 ok, 01 no space, 10 not found |
| rdCtrl | output | 32 | Control word of slot rdIdx |
| rdValue | output | 64 | Value word of slot rdIdx |

## Verification
The assertions assume `cmdOp` is stable and known while `cmdValid` is high. They also assume that at most one command arrives per cycle, which the single-strobe port enforces by itself.

The stimulus drives commands only on falling edges and drops `cmdValid` after each accepted edge. It draws addresses from a small pool, so duplicate values, bit-52 sign extension, high garbage bits and deletes of absent entries all occur often. `pc` and `rdIdx` are swept between edges, which only exercises the combinational paths.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int CTRL_W = 32;

  typedef enum logic [1:0] {
    OP_INSERT = 2'b00,
    OP_DELETE = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_NONE   = 2'b11
  } bkptOp_e;

  typedef enum logic [1:0] {
    ERR_OK       = 2'b00,
    ERR_NOSPACE  = 2'b01,
    ERR_NOTFOUND = 2'b10
  } bkptErr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic insertEn;
    logic removeEn;
    logic clearEn;
  } slotStb_t;

  // control word assembled field by field
  function automatic logic [CTRL_W-1:0] mkCtrlWord();
    logic [CTRL_W-1:0] w;
    w      = '0;
    w[0]   = 1'b1;     // enable
    w[2:1] = 2'b11;    // privilege: all levels
    w[8:5] = 4'b1111;  // byte select: all
    return w;
  endfunction

endpackage

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             findHit,
  output slotStb_t         stb,
  output logic [CNT_W-1:0] countQ,
  output logic             rspDone,
  output logic [1:0]       rspErr
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_SLOTS);

  bkptOp_e  opSel;
  bkptErr_e nextErr;

  assign opSel = bkptOp_e'(cmdOp);

  always_comb begin
    stb     = '0;
    nextErr = ERR_OK;
    if (cmdValid) begin
      unique case (opSel)
        OP_INSERT: begin
          if (countQ == MAX_CNT) nextErr = ERR_NOSPACE;
          else                   stb.insertEn = 1'b1;
        end
        OP_DELETE: begin
          if (findHit) stb.removeEn = 1'b1;
          else         nextErr = ERR_NOTFOUND;
        end
        OP_CLEAR: stb.clearEn = 1'b1;
        default:  nextErr = ERR_OK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      rspDone <= 1'b0;
      rspErr  <= ERR_OK;
    end else begin
      rspDone <= cmdValid;
      rspErr  <= cmdValid ? nextErr : ERR_OK;
      if (stb.clearEn)       countQ <= '0;
      else if (stb.insertEn) countQ <= countQ + 1'b1;
      else if (stb.removeEn) countQ <= countQ - 1'b1;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= MAX_CNT);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b00 && countQ == MAX_CNT)
      |=> (rspErr == 2'b01 && countQ == $past(countQ)));

  assert_delete_shrinks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b01 && findHit) |=> (countQ == $past(countQ) - 1'b1));

  assert_missing_delete_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b01 && !findHit)
      |=> (rspErr == 2'b10 && $stable(countQ)));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b10) |=> (countQ == '0));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> rspDone);

endmodule

// File: rtl/bkpt_store.sv
module bkpt_store
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int VAL_W     = 64,
  parameter int SEXT_BIT  = 52,
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1),
  parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStb_t          stb,
  input  logic [CNT_W-1:0]  count,
  input  logic [VAL_W-1:0]  cmdAddr,
  input  logic [VAL_W-1:0]  pc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              findHit,
  output logic              pcHit,
  output logic [CTRL_W-1:0] rdCtrl,
  output logic [VAL_W-1:0]  rdValue
);

  localparam int EXT_W = VAL_W - 1 - SEXT_BIT;
  localparam logic [CTRL_W-1:0] CTRL_WORD = mkCtrlWord();

  logic [CTRL_W-1:0] ctrlQ    [NUM_SLOTS];
  logic [VAL_W-1:0]  valueQ   [NUM_SLOTS];
  logic [CTRL_W-1:0] ctrlNext [NUM_SLOTS];
  logic [VAL_W-1:0]  valueNext[NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotActive, cmdMatch, pcMatch;
  logic [IDX_W-1:0] findIdx;
  logic [VAL_W-1:0] sextAddr;

  assign sextAddr = {{EXT_W{cmdAddr[SEXT_BIT]}}, cmdAddr[SEXT_BIT:0]};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slotActive[i] = count > CNT_W'(i);
    assign cmdMatch[i]   = slotActive[i] && (valueQ[i] == cmdAddr);
    assign pcMatch[i]    = slotActive[i] && (valueQ[i] == pc);

    // source for the shift-down path
    if (i == NUM_SLOTS - 1) begin : g_top
      assign ctrlNext[i]  = '0;
      assign valueNext[i] = '0;
    end else begin : g_mid
      assign ctrlNext[i]  = ctrlQ[i+1];
      assign valueNext[i] = valueQ[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN || stb.clearEn) begin
        ctrlQ[i]  <= '0;
        valueQ[i] <= '0;
      end else if (stb.removeEn && findIdx <= IDX_W'(i)) begin
        ctrlQ[i]  <= ctrlNext[i];
        valueQ[i] <= valueNext[i];
      end else if (stb.insertEn && count == CNT_W'(i)) begin
        ctrlQ[i]  <= CTRL_WORD;
        valueQ[i] <= sextAddr;
      end
    end

    assert_insert_words_R1: assert property (@(posedge clk) disable iff (!rstN)
      (stb.insertEn && count == CNT_W'(i))
        |=> (ctrlQ[i] == 32'h0000_01E7
             && valueQ[i][SEXT_BIT:0] == $past(cmdAddr[SEXT_BIT:0])
             && ((&valueQ[i][VAL_W-1:SEXT_BIT]) || !(|valueQ[i][VAL_W-1:SEXT_BIT]))));

    if (i < NUM_SLOTS - 1) begin : g_chk
      assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rstN)
        (stb.removeEn && findIdx <= IDX_W'(i))
          |=> (valueQ[i] == $past(valueQ[i+1]) && ctrlQ[i] == $past(ctrlQ[i+1])));
    end
  end

  // lowest matching index wins
  always_comb begin
    findHit = 1'b0;
    findIdx = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (cmdMatch[k]) begin
        findHit = 1'b1;
        findIdx = IDX_W'(k);
      end
    end
  end

  assign pcHit = |pcMatch;

  always_comb begin
    rdCtrl  = '0;
    rdValue = '0;
    if (CNT_W'(rdIdx) < count) begin
      rdCtrl  = ctrlQ[rdIdx];
      rdValue = valueQ[rdIdx];
    end
  end

  assert_inactive_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> !pcHit);

endmodule

// File: rtl/bkpt_pool.sv
module bkpt_pool
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int VAL_W     = 64,
  parameter int SEXT_BIT  = 52,
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1),
  parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [VAL_W-1:0]  cmdAddr,
  input  logic [VAL_W-1:0]  pc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              pcHit,
  output logic [CNT_W-1:0]  activeCount,
  output logic              full,
  output logic              debugActive,
  output logic              rspDone,
  output logic [1:0]        rspErr,
  output logic [CTRL_W-1:0] rdCtrl,
  output logic [VAL_W-1:0]  rdValue
);

  slotStb_t stb;
  logic     findHit;

  bkpt_ctrl #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .findHit(findHit), .stb(stb), .countQ(activeCount),
    .rspDone(rspDone), .rspErr(rspErr)
  );

  bkpt_store #(.NUM_SLOTS(NUM_SLOTS), .VAL_W(VAL_W), .SEXT_BIT(SEXT_BIT),
               .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .count(activeCount),
    .cmdAddr(cmdAddr), .pc(pc), .rdIdx(rdIdx), .findHit(findHit),
    .pcHit(pcHit), .rdCtrl(rdCtrl), .rdValue(rdValue)
  );

  assign full        = activeCount == CNT_W'(NUM_SLOTS);
  assign debugActive = activeCount != '0;

  assert_hit_needs_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    pcHit |-> debugActive);

  assert_full_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (debugActive && activeCount == CNT_W'(NUM_SLOTS)));

endmodule

// File: tb/bkpt_pool_bench.sv
`timescale 1ns/1ps
module bkpt_pool_bench;

  localparam int N     = 6;
  localparam int CNT_W = $clog2(N + 1);
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b11;
  logic [63:0] cmdAddr = '0;
  logic [63:0] pc = '0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic pcHit, full, debugActive, rspDone;
  logic [CNT_W-1:0] activeCount;
  logic [1:0] rspErr;
  logic [31:0] rdCtrl;
  logic [63:0] rdValue;

  int tests = 0;
  int fails = 0;
  logic [63:0] model[$];

  always #10 clk = ~clk;

  bkpt_pool u_bkpt_pool (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .pc(pc), .rdIdx(rdIdx), .pcHit(pcHit),
    .activeCount(activeCount), .full(full), .debugActive(debugActive),
    .rspDone(rspDone), .rspErr(rspErr), .rdCtrl(rdCtrl), .rdValue(rdValue)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sext(input logic [63:0] a);
    return {{11{a[52]}}, a[52:0]};
  endfunction

  function automatic bit modelHas(input logic [63:0] a);
    foreach (model[k]) if (model[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  // compare flags, read port and match port with the model
  task automatic checkState();
    chk("R7", "activeCount", 64'(activeCount), 64'(model.size()));
    chk("R7", "full", 64'(full), 64'(model.size() == N));
    chk("R7", "debugActive", 64'(debugActive), 64'(model.size() != 0));
    for (int i = 0; i < (1 << IDX_W); i++) begin
      rdIdx = IDX_W'(i);
      #1;
      chk("R1", "rdCtrl", 64'(rdCtrl), (i < model.size()) ? 64'h1E7 : 64'h0);
      chk("R10", "rdValue", rdValue, (i < model.size()) ? model[i] : 64'h0);
    end
    foreach (model[k]) begin
      pc = model[k];
      #1;
      chk("R6", "pcHit on entry", 64'(pcHit), 64'h1);
    end
    pc = 64'h0000_0000_0000_7777;
    #1;
    chk("R6", "pcHit on probe", 64'(pcHit), 64'(modelHas(pc)));
  endtask

  task automatic doCmd(input logic v, input logic [1:0] op, input logic [63:0] a);
    logic [1:0] expErr;
    int hitAt;
    @(negedge clk);
    cmdValid = v; cmdOp = op; cmdAddr = a;
    expErr = 2'b00;
    if (v) begin
      case (op)
        2'b00: if (model.size() == N) expErr = 2'b01; else model.push_back(sext(a));
        2'b01: begin
          hitAt = -1;
          foreach (model[k]) if (hitAt < 0 && model[k] == a) hitAt = k;
          if (hitAt < 0) expErr = 2'b10; else model.delete(hitAt);
        end
        2'b10: model.delete();
        default: expErr = 2'b00;
      endcase
    end
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
    chk("R9", "rspDone", 64'(rspDone), 64'(v));
    if (v) chk((op == 2'b00) ? "R3" : (op == 2'b01) ? "R5" : "R9",
               "rspErr", 64'(rspErr), 64'(expErr));
    checkState();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [63:0] pool[8];
    pool[0] = 64'h0000_0000_4000_1000;
    pool[1] = 64'h0010_0000_0000_2000;   // bit 52 set
    pool[2] = 64'hABC0_0000_0000_3000;   // junk above bit 52
    pool[3] = 64'h0000_0000_0000_3000;
    pool[4] = 64'hFFF0_0000_0000_2000;
    pool[5] = 64'h0000_0001_0000_0040;
    pool[6] = 64'h000F_FFFF_FFFF_FFFC;
    pool[7] = 64'h0000_0000_0000_7777;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R8", "rspDone after reset", 64'(rspDone), 64'h0);
    checkState();                         // R8 reset state

    doCmd(1, 2'b00, pool[0]);             // R1 R2 plain insert
    doCmd(1, 2'b00, pool[1]);             // R2 sign extension of bit 52
    doCmd(1, 2'b00, pool[2]);             // R2 high bits replaced
    doCmd(1, 2'b00, pool[5]);
    doCmd(1, 2'b00, pool[6]);
    doCmd(1, 2'b00, pool[0]);             // duplicate, table now full
    doCmd(1, 2'b00, pool[7]);             // R3 no space
    doCmd(1, 2'b01, pool[2]);             // R5 raw address is not stored value
    doCmd(1, 2'b01, pool[3]);             // R4 delete middle slot
    doCmd(1, 2'b11, pool[0]);             // R9 no-op op
    doCmd(0, 2'b00, pool[7]);             // R9 no strobe, no response
    doCmd(1, 2'b01, pool[0]);             // R4 first of duplicates
    doCmd(1, 2'b01, pool[4]);             // R4 delete sign-extended entry
    doCmd(1, 2'b10, '0);                  // R8 clear
    doCmd(1, 2'b01, pool[0]);             // R5 delete on empty table

    lfsr = 32'hACE1_1234;
    for (int s = 0; s < 400; s++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      // clear kept rare so the table fills up
      doCmd(1'b1, (lfsr[4:3] == 2'b10 && lfsr[7:5] != 3'b000) ? 2'b00 : lfsr[4:3],
            pool[lfsr[10:8]]);
    end

    // reset in the middle of a populated table
    doCmd(1, 2'b00, pool[5]);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    model.delete();
    rstN = 1'b1;
    chk("R8", "rspDone after mid reset", 64'(rspDone), 64'h0);
    checkState();

    summary();
    $finish;
  end

endmodule